// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two WIDTH-bit operands and returns the full 2*WIDTH-bit product, doing one add-and-shift iteration per clock. It is meant for datapaths where a multiply is rare enough that a single adder and one wide register are a better use of area than a full array multiplier. The caller presents both operands and a signedness flag together with a one-cycle start pulse. It then waits for the done pulse and reads the product, which holds its value until the next operation is accepted.

The datapath keeps the multiplier in the low half of a single product register. Each step examines bit 0 of that register and, when it is 1, adds the multiplicand into the upper half. The register then shifts right by one, and the carry of the addition enters the top bit. Signed operands are converted to magnitudes first. After the last iteration, one extra cycle negates the product when the operand signs differ.

Top module: `shift_add_mul`

## Requirements
- R1: With `signed_i` = 0, the product equals the unsigned product of `a_i` and `b_i` over all 2*WIDTH bits.
- R2: The carry out of each addition is kept, so all-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1.
- R3: With `signed_i` = 1, both operands are read as two's complement and the product is their two's complement product over 2*WIDTH bits.
- R4: With `signed_i` = 1, the most negative value times itself gives 2^(2*WIDTH-2), and the most negative value times -1 gives 2^(WIDTH-1).
- R5: `done_o` is high in the cycle after the (WIDTH+1)-th rising edge that follows the edge that accepted `start_i`.
- R6: `done_o` is high for exactly one cycle per operation.
- R7: `busy_o` is high from the cycle after an accepted start until the cycle before `done_o`, and it is low while `done_o` is high.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation finishes with the operands it captured.
- R9: While no start is accepted, `prod_o` keeps the last result for any number of cycles, whatever the operand inputs do.
- R10: After reset, `busy_o` and `done_o` are low and `prod_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| start_i | input | 1 | Starts an operation when high and the block is idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned operands |
| a_i | input | WIDTH | Multiplicand |
| b_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle pulse; the product is valid |
| prod_o | output | 2*WIDTH | Product |

## Verification
The bench builds the block at its default WIDTH of 32, so the expected products can be computed in 64-bit arithmetic inside the bench. This width reaches the extremes that stress the datapath. All-ones squared exercises the carry into bit 63 on almost every step. The most negative 32-bit value exercises magnitudes that do not fit in a signed 32-bit number. The 34-cycle run also leaves room to inject a start pulse partway through an operation and to watch the product hold for several idle cycles afterwards.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SIGN = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_operand_prep.sv
// Converts operands to magnitudes and computes the sign of the result.
module mul_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] mag_a_o,
  output logic [WIDTH-1:0] mag_b_o,
  output logic             neg_o
);
  localparam int MSB = WIDTH - 1;

  logic a_neg;
  logic b_neg;

  always_comb begin
    a_neg   = signed_i & a_i[MSB];
    b_neg   = signed_i & b_i[MSB];
    // The most negative value maps to itself, which is correct when read unsigned.
    mag_a_o = a_neg ? (~a_i + 1'b1) : a_i;
    mag_b_o = b_neg ? (~b_i + 1'b1) : b_i;
    neg_o   = a_neg ^ b_neg;
  end
endmodule

// File: rtl/mul_seq_ctrl.sv
// Sequencer: idle, WIDTH iteration cycles, one sign-correction cycle.
module mul_seq_ctrl
  import mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fix_o   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          state_d = ST_SIGN;
        end
      end
      ST_SIGN: begin
        fix_o   = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/mul_datapath.sv
// Single product register; the multiplier sits in the low half and shifts out.
module mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               fix_i,
  input  logic [WIDTH-1:0]   mag_a_i,
  input  logic [WIDTH-1:0]   mag_b_i,
  input  logic               neg_i,
  output logic [2*WIDTH-1:0] prod_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic             neg_q;
  logic [PW-1:0]    prod_q, prod_d;
  logic             prod_en;
  logic [WIDTH:0]   upper_sum;
  logic [WIDTH:0]   upper_sel;

  always_comb begin
    upper_sum = {1'b0, prod_q[PW-1:WIDTH]} + {1'b0, mcand_q};
    upper_sel = prod_q[0] ? upper_sum : {1'b0, prod_q[PW-1:WIDTH]};
    prod_en   = load_i | step_i | fix_i;
    prod_d    = prod_q;
    if (load_i) begin
      prod_d = {{WIDTH{1'b0}}, mag_b_i};
    end else if (step_i) begin
      prod_d = {upper_sel, prod_q[WIDTH-1:1]};
    end else if (fix_i) begin
      prod_d = neg_q ? (~prod_q + 1'b1) : prod_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      neg_q   <= 1'b0;
    end else if (load_i) begin
      mcand_q <= mag_a_i;
      neg_q   <= neg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
    end else if (prod_en) begin
      prod_q <= prod_d;
    end
  end

  assign prod_o = prod_q;
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] prod_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] mag_a;
  logic [WIDTH-1:0] mag_b;
  logic             neg;
  logic             load;
  logic             step;
  logic             fix;

  // Reset asserts asynchronously and is released synchronously.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  mul_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .a_i      (a_i),
    .b_i      (b_i),
    .signed_i (signed_i),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .neg_o    (neg)
  );

  mul_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .fix_o   (fix),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_i  (load),
    .step_i  (step),
    .fix_i   (fix),
    .mag_a_i (mag_a),
    .mag_b_i (mag_b),
    .neg_i   (neg),
    .prod_o  (prod_o)
  );
endmodule

// File: rtl/shift_add_mul_chk.sv
module shift_add_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic [2*WIDTH-1:0] prod_o
);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R5
  done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));

  // R9
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

bind shift_add_mul shift_add_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .prod_o  (prod_o)
);

// File: tb/sim_shift_add_mul.sv
`timescale 1ns/1ps
module sim_shift_add_mul;
  localparam int W = 32;

  logic           clk;
  logic           rst_n;
  logic           start_i;
  logic           signed_i;
  logic [W-1:0]   a_i;
  logic [W-1:0]   b_i;
  logic           busy_o;
  logic           done_o;
  logic [2*W-1:0] prod_o;

  int checks;
  int errors;
  bit finished;

  shift_add_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .prod_o(prod_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg);
    logic [2*W-1:0] ea;
    logic [2*W-1:0] eb;
    ea = sg ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    eb = sg ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return ea * eb;
  endfunction

  // Launches one operation and checks latency, busy, done pulse and result.
  // If inject is set, a second start with other operands is driven mid-run (R8).
  task automatic run_op(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sg, input bit inject);
    logic [2*W-1:0] exp;
    int cyc;
    bit busy_bad;
    exp = model(a, b, sg);
    @(negedge clk);
    a_i = a; b_i = b; signed_i = sg; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    busy_bad = 1'b0;
    while (!done_o && cyc < 100) begin
      if (!busy_o) busy_bad = 1'b1;
      if (inject && cyc == 5) begin
        a_i = 32'h1234_5678; b_i = 32'h0000_0003; signed_i = ~sg; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk({tag, " R5 latency"}, 64'(cyc), 64'(W + 2));
    chk({tag, " R7 busy during run"}, {63'b0, busy_bad}, 64'd0);
    chk({tag, " R7 busy low at done"}, {63'b0, busy_o}, 64'd0);
    chk({tag, inject ? " R8 product" : " product"}, prod_o, exp);
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, {63'b0, done_o}, 64'd0);
    chk({tag, " R9 product after done"}, prod_o, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 busy after reset", {63'b0, busy_o}, 64'd0);
    chk("R10 done after reset", {63'b0, done_o}, 64'd0);
    chk("R10 product after reset", prod_o, 64'd0);
  endtask

  task automatic t_unsigned;
    run_op("R1 zero",      32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 1'b0);
    run_op("R1 small",     32'd12345,     32'd6789,      1'b0, 1'b0);
    run_op("R1 mixed",     32'h8000_0001, 32'hF0F0_0F0F, 1'b0, 1'b0);
    run_op("R2 all ones",  32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0);
  endtask

  task automatic t_signed;
    run_op("R3 neg pos",   32'hFFFF_FFF9, 32'd13,        1'b1, 1'b0);
    run_op("R3 neg neg",   32'hFFFF_0000, 32'h8765_4321, 1'b1, 1'b0);
    run_op("R3 minus ones",32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
    run_op("R3 pos pos",   32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, 1'b0);
    run_op("R4 min sq",    32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0);
    run_op("R4 min m1",    32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0);
  endtask

  task automatic t_busy_start;
    run_op("R8 start while busy", 32'hCAFE_0001, 32'h0BAD_F00D, 1'b0, 1'b1);
  endtask

  task automatic t_hold;
    logic [2*W-1:0] exp;
    exp = model(32'h0001_0003, 32'h0002_0005, 1'b0);
    run_op("R9 setup", 32'h0001_0003, 32'h0002_0005, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) begin
      a_i = 32'h5555_0000 + 32'(i); b_i = ~b_i; signed_i = ~signed_i;
      @(negedge clk);
    end
    chk("R9 product held while idle", prod_o, exp);
    chk("R9 still idle", {62'b0, busy_o, done_o}, 64'd0);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    t_reset();
    t_unsigned();
    t_signed();
    t_busy_start();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule